// File: doc/BRIEF.md
# Maritime Transmit Frame Formatter

This block turns a stream of payload bytes, drawn from a show-ahead byte FIFO, into the serial bit stream that feeds the transmit modulator. In framed mode a frame consists of four parts in order. First comes a training preamble of alternating bits. Then comes an opening flag. After that come the payload bytes and a 16-bit check sequence, with zero insertion applied to both. A closing flag ends the frame. Every bit the block emits, in either mode, passes through a non-return-to-zero-inverted line coder before it reaches the output pin.

A one-cycle strobe from the bit-rate generator sets the pace. The block emits one line bit per strobe and stays still between strobes. A start pulse launches a frame. The host marks the final payload byte with a flag that sits alongside the byte in the FIFO. If the FIFO runs dry while a byte is still needed, the frame stops and the block reports an underrun. A raw mode skips the preamble, the flags, the zero insertion and the check sequence, and serialises the host bytes exactly as they arrive.

Top module: `ais_tx_framer`

## Requirements
- R1: While reset is held, and afterwards until a start is taken, `tx_line` is 0 and `busy`, `done`, `underrun` and `fifo_rd` are all 0.
- R2: A `start` pulse seen while idle sets `busy` in the next cycle and latches `raw_sel`. A `start` pulse seen while busy is ignored.
- R3: Line bits advance only in cycles where `bit_en` is 1 and the block is busy. In every other cycle `tx_line` holds its value.
- R4: Line coding: an outgoing 0 inverts `tx_line` and an outgoing 1 leaves it unchanged. The new level appears in the cycle after the `bit_en` cycle that sent the bit.
- R5: A framed transmission sends its parts in this order: 24 preamble bits 0,1,0,1,… (0 first); the flag bits 0,1,1,1,1,1,1,0; each payload byte, least significant bit first; the check sequence; the same flag again.
- R6: Whenever five 1s in a row have been sent within the payload and check-sequence bits, a 0 is inserted after them. This holds across byte boundaries and at the end of the check sequence. No 0 is inserted in the preamble or in either flag, and a run of 1s in a flag does not count toward the next run.
- R7: The check sequence is computed bit by bit over the payload bits, before zero insertion, in sending order. The register starts at 0xFFFF, shifts right, and XORs in 0x8408 whenever the bit shifted out differs from the input bit. The inverse of the final register is sent, bit 0 first.
- R8: `fifo_rd` pulses for one cycle, and only in a `bit_en` cycle, when a new byte is needed and `fifo_valid` is 1. In that same cycle the block takes in `fifo_data` and `fifo_last`. Bit 0 of the byte is the bit sent in that event.
- R9: In raw mode the bytes are sent least significant bit first, back to back, with no preamble, flags, zero insertion or check sequence. The frame ends after the last bit of the byte that carried `fifo_last`.
- R10: `done` is a one-cycle pulse in the cycle after the final bit event of a frame. `busy` falls in that same cycle.
- R11: If a byte is needed while `fifo_valid` is 0, no bit is sent and `tx_line` holds. In the next cycle `underrun` pulses for one cycle, `busy` falls and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate strobe; one line bit per strobe |
| start | input | 1 | Begin a frame (taken only when idle) |
| raw_sel | input | 1 | Mode latched at start: 1 raw, 0 framed |
| fifo_valid | input | 1 | FIFO holds at least one byte |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_last | input | 1 | Head byte is the final byte of the frame |
| fifo_rd | output | 1 | Pop the head byte |
| tx_line | output | 1 | Line-coded serial output |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame completion |
| underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
Several payloads go through framed mode. All-ones bytes force zero insertion across byte boundaries and into the check sequence. Mixed bytes produce a check sequence of no special form. A byte equal to the flag pattern tests that payload data cannot pass for a flag. The strobe runs every cycle, every third cycle and in an irregular pattern, which separates hold behaviour from per-cycle stepping. The same ones-heavy bytes also go through raw mode, which separates the bypass from the framed path. An empty FIFO at the first fetch, and a frame that runs dry partway through, cover the two underrun positions. A start pulse sent in mid-frame confirms that a running frame ignores it.

// File: rtl/ais_tx_pkg.sv
package ais_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_OPEN,
    ST_DATA,
    ST_CHK,
    ST_CLOSE
  } fr_state_t;

  localparam int CHK_W = 16;

  // One reflected check-sequence step: shift right, fold polynomial on mismatch.
  function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] cur,
                                                input logic in_bit,
                                                input logic [CHK_W-1:0] poly);
    logic [CHK_W-1:0] nxt;
    nxt = cur >> 1;
    if (cur[0] ^ in_bit) nxt = nxt ^ poly;
    return nxt;
  endfunction

  // Line coding: a 0 inverts the level, a 1 keeps it.
  function automatic logic line_next(input logic level, input logic in_bit);
    return in_bit ? level : ~level;
  endfunction

endpackage

// File: rtl/ais_tx_chk_acc.sv
module ais_tx_chk_acc
  import ais_tx_pkg::*;
#(
  parameter logic [CHK_W-1:0] POLY = 16'h8408,
  parameter logic [CHK_W-1:0] SEED = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_en,
  input  logic             step,
  input  logic             in_bit,
  output logic [CHK_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || seed_en) acc_q <= SEED;
    else if (step)         acc_q <= chk_step(acc_q, in_bit, POLY);
  end
endmodule

// File: rtl/ais_tx_ones_run.sv
module ais_tx_ones_run #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic in_bit,
  output logic insert_now,
  output logic full_next
);
  localparam int CNT_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] RUN_V  = CNT_W'(RUN);
  localparam logic [CNT_W-1:0] RUN_M1 = CNT_W'(RUN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign insert_now = (cnt_q == RUN_V);
  assign full_next  = step && in_bit && (cnt_q == RUN_M1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step)       cnt_q <= in_bit ? cnt_q + 1'b1 : '0;
  end
endmodule

// File: rtl/ais_tx_line.sv
module ais_tx_line
  import ais_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic in_bit,
  output logic level_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    level_q <= 1'b0;
    else if (step) level_q <= line_next(level_q, in_bit);
  end
endmodule

// File: rtl/ais_tx_framer.sv
module ais_tx_framer
  import ais_tx_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          PRE_BITS = 24,
  parameter int          RUN      = 5,
  parameter logic [7:0]  FLAG     = 8'h7E,
  parameter logic [15:0] POLY     = 16'h8408,
  parameter logic [15:0] SEED     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              start,
  input  logic              raw_sel,
  input  logic              fifo_valid,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_last,
  output logic              fifo_rd,
  output logic              tx_line,
  output logic              busy,
  output logic              done,
  output logic              underrun
);
  localparam int MAX_A = (PRE_BITS > CHK_W) ? PRE_BITS : CHK_W;
  localparam int MAX_N = (MAX_A > BYTE_W) ? MAX_A : BYTE_W;
  localparam int IDX_W = $clog2(MAX_N + 1);
  localparam int CIX_W = $clog2(CHK_W);
  localparam logic [IDX_W-1:0] PRE_LAST  = IDX_W'(PRE_BITS - 1);
  localparam logic [IDX_W-1:0] FLAG_LAST = IDX_W'(7);
  localparam logic [IDX_W-1:0] BYTE_END  = IDX_W'(BYTE_W);
  localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] CHK_END   = IDX_W'(CHK_W);
  localparam logic [IDX_W-1:0] CHK_LAST  = IDX_W'(CHK_W - 1);

  fr_state_t         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sreg_q;
  logic              last_q, raw_q, done_q, und_q;

  // Named internal events (used by the checker).
  logic fire, stuffable, insert_now, full_next, need_fetch, starve;
  logic line_step, data_bit, chk_step_en;
  logic [CHK_W-1:0] acc_q;

  assign fire       = bit_en && (state_q != ST_IDLE);
  assign stuffable  = !raw_q && (state_q == ST_DATA || state_q == ST_CHK);
  assign need_fetch = (state_q == ST_DATA) && (idx_q == BYTE_END) && !insert_now;
  assign fifo_rd    = fire && need_fetch && fifo_valid;
  assign starve     = fire && need_fetch && !fifo_valid;
  assign line_step  = fire && !starve;
  assign chk_step_en = line_step && (state_q == ST_DATA) && !raw_q && !insert_now;

  always_comb begin
    data_bit = 1'b0;
    unique case (state_q)
      ST_PRE:           data_bit = idx_q[0];
      ST_OPEN, ST_CLOSE: data_bit = FLAG[idx_q[2:0]];
      ST_DATA: begin
        if (insert_now)      data_bit = 1'b0;
        else if (need_fetch) data_bit = fifo_data[0];
        else                 data_bit = sreg_q[0];
      end
      ST_CHK:  data_bit = insert_now ? 1'b0 : ~acc_q[idx_q[CIX_W-1:0]];
      default: data_bit = 1'b0;
    endcase
  end

  ais_tx_chk_acc #(.POLY(POLY), .SEED(SEED)) u_acc (
    .clk(clk), .rst_n(rst_n), .seed_en(state_q == ST_IDLE),
    .step(chk_step_en), .in_bit(data_bit), .acc_q(acc_q)
  );

  ais_tx_ones_run #(.RUN(RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .clear(!stuffable),
    .step(line_step && stuffable), .in_bit(data_bit),
    .insert_now(insert_now), .full_next(full_next)
  );

  ais_tx_line u_line (
    .clk(clk), .rst_n(rst_n), .step(line_step), .in_bit(data_bit), .level_q(tx_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sreg_q  <= '0;
      last_q  <= 1'b0;
      raw_q   <= 1'b0;
      done_q  <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      und_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          raw_q  <= raw_sel;
          last_q <= 1'b0;
          if (raw_sel) begin state_q <= ST_DATA; idx_q <= BYTE_END; end
          else         begin state_q <= ST_PRE;  idx_q <= '0;       end
        end
        ST_PRE: if (fire) begin
          if (idx_q == PRE_LAST) begin state_q <= ST_OPEN; idx_q <= '0; end
          else idx_q <= idx_q + 1'b1;
        end
        ST_OPEN: if (fire) begin
          if (idx_q == FLAG_LAST) begin state_q <= ST_DATA; idx_q <= BYTE_END; end
          else idx_q <= idx_q + 1'b1;
        end
        ST_DATA: if (fire) begin
          if (insert_now) begin
            if (idx_q == BYTE_END && last_q) begin state_q <= ST_CHK; idx_q <= '0; end
          end else if (need_fetch) begin
            if (fifo_valid) begin
              sreg_q <= fifo_data >> 1;
              idx_q  <= IDX_W'(1);
              last_q <= fifo_last;
            end else begin
              state_q <= ST_IDLE;
              und_q   <= 1'b1;
            end
          end else begin
            sreg_q <= sreg_q >> 1;
            idx_q  <= idx_q + 1'b1;
            if (idx_q == BYTE_LAST && last_q && !full_next) begin
              if (raw_q) begin state_q <= ST_IDLE; done_q <= 1'b1; end
              else       begin state_q <= ST_CHK;  idx_q <= '0;    end
            end
          end
        end
        ST_CHK: if (fire) begin
          if (insert_now) begin
            if (idx_q == CHK_END) begin state_q <= ST_CLOSE; idx_q <= '0; end
          end else begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == CHK_LAST && !full_next) begin state_q <= ST_CLOSE; idx_q <= '0; end
          end
        end
        ST_CLOSE: if (fire) begin
          if (idx_q == FLAG_LAST) begin state_q <= ST_IDLE; done_q <= 1'b1; end
          else idx_q <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign underrun = und_q;

endmodule

// File: rtl/ais_tx_framer_chk.sv
module ais_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic start,
  input logic fifo_valid,
  input logic fifo_rd,
  input logic tx_line,
  input logic busy,
  input logic done,
  input logic underrun,
  input logic line_step,
  input logic data_bit
);
  // R8
  pop_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (fifo_valid && bit_en && busy));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_step |=> $stable(tx_line));

  // R4
  zero_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_step && !data_bit) |=> (tx_line != $past(tx_line)));

  // R4
  one_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_step && data_bit) |=> $stable(tx_line));

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !underrun));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!busy && $stable(tx_line)));
endmodule

bind ais_tx_framer ais_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
  .fifo_valid(fifo_valid), .fifo_rd(fifo_rd), .tx_line(tx_line),
  .busy(busy), .done(done), .underrun(underrun),
  .line_step(line_step), .data_bit(data_bit)
);

// File: tb/ais_tx_framer_test.sv
module ais_tx_framer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, start = 1'b0, raw_sel = 1'b0;
  logic fifo_valid = 1'b0, fifo_last = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic fifo_rd, tx_line, busy, done, underrun;

  int checks = 0, errors = 0;

  // FIFO model and expected-event model
  logic [7:0] fq[$];
  bit         lq[$];
  int         ev_q[$];   // 0/1 bit, +10 when it pops a byte, 2 = underrun
  logic [7:0] payload[$];
  logic exp_line = 1'b0, exp_busy = 1'b0, exp_done = 1'b0, exp_und = 1'b0;
  bit   rd_seen = 1'b0;

  ais_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start), .raw_sel(raw_sel),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_rd(fifo_rd), .tx_line(tx_line), .busy(busy), .done(done), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  // Byte-wise reflected check sequence, written independently
  function automatic logic [15:0] fcs_of(input logic [7:0] bytes[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (bytes[i]) begin
      c = c ^ {8'h00, bytes[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bit be_of(input int pat, input int i);
    case (pat)
      0: return 1'b1;
      1: return (i % 3) == 0;
      default: return ((i % 5) == 0) || ((i % 7) == 2);
    endcase
  endfunction

  task automatic build(input bit raw, input bit with_last);
    int ones = 0;
    logic [15:0] f;
    ev_q.delete();
    foreach (payload[i]) begin
      fq.push_back(payload[i]);
      lq.push_back(with_last && (i == payload.size() - 1));
    end
    if (!raw) begin
      for (int i = 0; i < 24; i++) ev_q.push_back(i % 2);
      ev_q.push_back(0); for (int i = 0; i < 6; i++) ev_q.push_back(1); ev_q.push_back(0);
    end
    foreach (payload[i]) begin
      for (int k = 0; k < 8; k++) begin
        int b = (payload[i] >> k) & 1;
        if (!raw && ones == 5) begin ev_q.push_back(0); ones = 0; end
        ev_q.push_back(b + ((k == 0) ? 10 : 0));
        ones = b ? ones + 1 : 0;
      end
    end
    if (!with_last) begin
      if (!raw && ones == 5) ev_q.push_back(0);
      ev_q.push_back(2);
      return;
    end
    if (raw) return;
    f = ~fcs_of(payload);
    for (int k = 0; k < 16; k++) begin
      int b = f[k];
      if (ones == 5) begin ev_q.push_back(0); ones = 0; end
      ev_q.push_back(b);
      ones = b ? ones + 1 : 0;
    end
    if (ones == 5) ev_q.push_back(0);
    ev_q.push_back(0); for (int i = 0; i < 6; i++) ev_q.push_back(1); ev_q.push_back(0);
  endtask

  // Called just after a falling edge; ends at the next falling edge.
  task automatic cycle(input bit be, input bit st, input bit rm);
    bit exp_pop = 1'b0, nd = 1'b0, nu = 1'b0;
    if (rd_seen) begin void'(fq.pop_front()); void'(lq.pop_front()); end
    fifo_valid = (fq.size() > 0);
    fifo_data  = (fq.size() > 0) ? fq[0] : 8'hxx;
    fifo_last  = (lq.size() > 0) ? lq[0] : 1'b0;
    chk(tx_line === exp_line, "R4", "tx_line", tx_line, exp_line);
    chk(busy === exp_busy, "R10", "busy", busy, exp_busy);
    chk(done === exp_done, "R10", "done", done, exp_done);
    chk(underrun === exp_und, "R11", "underrun", underrun, exp_und);
    bit_en = be; start = st; raw_sel = rm;
    #1;
    if (!exp_busy) begin
      if (st) exp_busy = 1'b1;
    end else if (be) begin
      int e = ev_q.pop_front();
      if (e == 2) begin
        nu = 1'b1; exp_busy = 1'b0;
      end else begin
        exp_pop = (e >= 10);
        if ((e % 10) == 0) exp_line = ~exp_line;
        if (ev_q.size() == 0) begin exp_busy = 1'b0; nd = 1'b1; end
      end
    end
    chk(fifo_rd === exp_pop, "R8", "fifo_rd", fifo_rd, exp_pop);
    rd_seen  = fifo_rd;
    exp_done = nd;
    exp_und  = nu;
    @(negedge clk);
  endtask

  task automatic run_frame(input bit raw, input bit with_last, input int pat,
                           input bit mid_start, input string tag);
    int e0 = errors;
    int i = 0;
    build(raw, with_last);
    cycle(1'b0, 1'b1, raw);
    while (exp_busy && i < 5000) begin
      cycle(be_of(pat, i), mid_start && (i == 40), 1'b0);
      i++;
    end
    for (int j = 0; j < 4; j++) cycle(j % 2, 1'b0, 1'b0);
    chk(errors == e0, tag, "frame mismatches", errors - e0, 0);
    fq.delete(); lq.delete();
  endtask

  initial begin
    logic [7:0] ref9[$];
    repeat (3) @(negedge clk);
    // R1: outputs at rest in reset
    chk({tx_line, busy, done, underrun, fifo_rd} === 5'b0, "R1", "reset outputs",
        {tx_line, busy, done, underrun, fifo_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cycle(1'b1, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 1'b0);
    chk({tx_line, busy} === 2'b0, "R1", "idle after reset", {tx_line, busy}, 0);

    // R7: bench model against a well-known value
    ref9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk((~fcs_of(ref9) & 16'hFFFF) == 16'h906E, "R7", "model fcs", ~fcs_of(ref9), 16'h906E);

    // R6: ones runs across byte boundaries, strobe every cycle
    payload = '{8'hFF, 8'hFF, 8'h3E};
    run_frame(1'b0, 1'b1, 0, 1'b0, "R6");

    // R5 and R2: mixed bytes, slow strobe, start during the frame
    payload = '{8'hA5, 8'h01, 8'hC3};
    run_frame(1'b0, 1'b1, 1, 1'b1, "R2");

    // R7: single flag-valued byte, irregular strobe
    payload = '{8'h7E};
    run_frame(1'b0, 1'b1, 2, 1'b0, "R7");

    // R5: longer payload with every-cycle strobe
    payload = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
    run_frame(1'b0, 1'b1, 0, 1'b0, "R5");

    // R9: raw mode, ones-heavy bytes, no stuffing expected
    payload = '{8'hF0, 8'h0F, 8'hFF, 8'hFF};
    run_frame(1'b1, 1'b1, 1, 1'b0, "R9");

    // R11: frame runs dry after two bytes
    payload = '{8'hFF, 8'h1F};
    run_frame(1'b0, 1'b0, 0, 1'b0, "R11");

    // R11: empty FIFO at the first fetch
    payload.delete();
    run_frame(1'b0, 1'b0, 2, 1'b0, "R11");

    // R3: strobe held low while idle leaves the line alone
    for (int j = 0; j < 5; j++) cycle(1'b0, 1'b0, 1'b0);
    chk(busy === 1'b0, "R3", "idle hold", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule